// File: doc/BRIEF.md
# SDRAM Refresh Interval Generator

This block tells an SDRAM command sequencer when a refresh is due. A 2-bit rate code picks one of three refresh periods or switches refresh off. A 2-bit clock-select code says which of three controller clock frequencies is in use. The block converts the chosen period into a count of controller clock cycles for that frequency. A down counter runs over that count. Each time the counter expires, one more refresh becomes owed.

The refresh request stays high while at least one refresh is owed. The sequencer pulses the acknowledge input once for each refresh it issues, and each pulse retires one owed refresh. The owed count is a port, so the sequencer can see how far behind it is. It saturates at a parameterised ceiling.

Control is a three-state machine:
- `ST_OFF`: refresh is disabled.
- `ST_IDLE`: refresh is enabled and nothing is owed.
- `ST_PEND`: the request is raised.

Its transitions are:
- `T_ENABLE` (ST_OFF to ST_IDLE): the rate code becomes nonzero.
- `T_EXPIRE` (ST_IDLE to ST_PEND): an interval expires.
- `T_DRAIN` (ST_PEND to ST_IDLE): the last owed refresh is acknowledged and no interval expires in the same cycle.
- `T_DISABLE` (any state to ST_OFF): the rate code returns to zero.

Top module: `refi_gen`

## Requirements
- R1: Rate code 00 disables refresh. One clock edge later the owed count is 0 and the request is low. While the code stays 00, acknowledge pulses change nothing.
- R2: Rate codes 01, 10 and 11 select the periods RATE1_NS, RATE2_NS and RATE3_NS. Their defaults are 7800, 15600 and 125000 ns. The interval in cycles is floor(period_ns × MHz / 1000), with a minimum of 1.
- R3: Clock-select code 00 selects F0_MHZ (default 66). Code 01 selects F1_MHZ (default 100). Codes 10 and 11 both select F2_MHZ (default 133).
- R4: Take the edge at which a new nonzero rate code, or a new clock-select code, is first sampled. The first expiry happens L edges after that edge, where L is the interval in cycles. The owed count and the request reflect that expiry right after the expiring edge.
- R5: While at least one refresh is owed, the request stays high until acknowledged. Each acknowledge sampled with a nonzero owed count lowers the count by one.
- R6: Each expiry raises the owed count by one. The count saturates at OWED_MAX (default 7).
- R7: A change of rate or clock-select code while enabled restarts the interval count from the new interval. The owed count is kept.
- R8: An expiry and an acknowledge in the same cycle leave the owed count unchanged. An acknowledge with nothing owed is ignored. The owed count moves by at most one per cycle.
- R9: After reset the request is low and the owed count is 0.
- R10: The request is high exactly when the owed count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Refresh rate code (00 off, 01/10/11 periods) |
| freq_sel | input | 2 | Controller clock frequency code |
| refresh_ack | input | 1 | One-cycle pulse per refresh issued |
| refresh_req | output | 1 | High while a refresh is owed |
| owed_count | output | OWED_W | Number of refreshes owed (saturating) |

## Verification
The bench builds the block with the periods shrunk to 100, 200 and 1600 ns and keeps the default 66/100/133 MHz clocks and a ceiling of 7. This gives intervals of 6 to 212 cycles. Every period and clock combination, saturation at seven owed refreshes, and many expiry-versus-acknowledge collisions then fit in a few thousand cycles. With the default periods, the longest interval alone would be over sixteen thousand cycles.

// File: rtl/refi_pkg.sv
package refi_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_PEND = 2'd2
    } refi_state_e;

    // Cycles in one interval: floor(ns * MHz / 1000), never below one.
    function automatic int unsigned refi_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/refi_interval_table.sv
module refi_interval_table
    import refi_pkg::*;
#(
    parameter int unsigned RATE1_NS = 7800,
    parameter int unsigned RATE2_NS = 15600,
    parameter int unsigned RATE3_NS = 125000,
    parameter int unsigned F0_MHZ   = 66,
    parameter int unsigned F1_MHZ   = 100,
    parameter int unsigned F2_MHZ   = 133,
    parameter int unsigned CNT_W    = 15
) (
    input  logic [1:0]       rate_sel,
    input  logic [1:0]       freq_sel,
    output logic [CNT_W-1:0] reload_val
);

    function automatic int unsigned period_of(input int unsigned r);
        case (r)
            1:       return RATE1_NS;
            2:       return RATE2_NS;
            3:       return RATE3_NS;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned clock_of(input int unsigned f);
        case (f)
            0:       return F0_MHZ;
            1:       return F1_MHZ;
            default: return F2_MHZ;
        endcase
    endfunction

    logic [CNT_W-1:0] tbl [4][4];

    for (genvar r = 0; r < 4; r++) begin : g_rate
        for (genvar f = 0; f < 4; f++) begin : g_freq
            if (r == 0) begin : g_off
                assign tbl[r][f] = '0;
            end else begin : g_on
                assign tbl[r][f] = CNT_W'(refi_cycles(period_of(r), clock_of(f)) - 1);
            end
        end
    end

    assign reload_val = tbl[rate_sel][freq_sel];

endmodule

// File: rtl/refi_down_counter.sv
module refi_down_counter #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    assign expire = run && !reload && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (reload || !run || (cnt == '0)) begin
            cnt <= reload_val;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/refi_owed_tracker.sv
module refi_owed_tracker #(
    parameter int unsigned OWED_MAX = 7,
    parameter int unsigned OWED_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    input  logic              dec,
    output logic [OWED_W-1:0] owed
);

    localparam logic [OWED_W-1:0] CAP = OWED_W'(OWED_MAX);

    logic dec_ok;
    assign dec_ok = dec && (owed != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (clear) begin
            owed <= '0;
        end else begin
            unique case ({inc, dec_ok})
                2'b10:   owed <= (owed == CAP) ? owed : owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

endmodule

// File: rtl/refi_gen.sv
module refi_gen
    import refi_pkg::*;
#(
    parameter int unsigned RATE1_NS = 7800,
    parameter int unsigned RATE2_NS = 15600,
    parameter int unsigned RATE3_NS = 125000,
    parameter int unsigned F0_MHZ   = 66,
    parameter int unsigned F1_MHZ   = 100,
    parameter int unsigned F2_MHZ   = 133,
    parameter int unsigned OWED_MAX = 7,
    localparam int unsigned OWED_W  = $clog2(OWED_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        freq_sel,
    input  logic              refresh_ack,
    output logic              refresh_req,
    output logic [OWED_W-1:0] owed_count
);

    localparam int unsigned MAX_CYC = refi_cycles(RATE3_NS, F2_MHZ);
    localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic [3:0]       cfg_q;
    logic             enabled;
    logic             cfg_change;
    logic [CNT_W-1:0] reload_val;
    logic             expire;
    refi_state_e      state, state_nxt;

    assign enabled    = (rate_sel != 2'b00);
    assign cfg_change = ({rate_sel, freq_sel} != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= {rate_sel, freq_sel};
    end

    refi_interval_table #(
        .RATE1_NS(RATE1_NS), .RATE2_NS(RATE2_NS), .RATE3_NS(RATE3_NS),
        .F0_MHZ(F0_MHZ), .F1_MHZ(F1_MHZ), .F2_MHZ(F2_MHZ), .CNT_W(CNT_W)
    ) u_table (
        .rate_sel   (rate_sel),
        .freq_sel   (freq_sel),
        .reload_val (reload_val)
    );

    refi_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enabled),
        .reload     (cfg_change),
        .reload_val (reload_val),
        .expire     (expire)
    );

    refi_owed_tracker #(.OWED_MAX(OWED_MAX), .OWED_W(OWED_W)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!enabled),
        .inc   (expire),
        .dec   (refresh_ack),
        .owed  (owed_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (enabled) state_nxt = ST_IDLE;               // T_ENABLE
            end
            ST_IDLE: begin
                if (!enabled)    state_nxt = ST_OFF;            // T_DISABLE
                else if (expire) state_nxt = ST_PEND;           // T_EXPIRE
            end
            ST_PEND: begin
                if (!enabled) state_nxt = ST_OFF;               // T_DISABLE
                else if (refresh_ack && !expire && (owed_count == OWED_W'(1)))
                    state_nxt = ST_IDLE;                        // T_DRAIN
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_comb begin
        refresh_req = (state == ST_PEND);
    end

endmodule

// File: rtl/refi_gen_chk.sv
module refi_gen_chk #(
    parameter int unsigned OWED_MAX = 7,
    parameter int unsigned OWED_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rate_sel,
    input logic              refresh_ack,
    input logic              refresh_req,
    input logic [OWED_W-1:0] owed_count
);

    // R1
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00) |=> (owed_count == '0) && !refresh_req);

    // R6
    owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(owed_count) <= OWED_MAX);

    // R10
    req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req == (owed_count != '0));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && !refresh_ack && (rate_sel != 2'b00)) |=> refresh_req);

    // R8
    owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != 2'b00) |=>
            ((32'(owed_count) + 1 >= 32'($past(owed_count))) &&
             (32'(owed_count) <= 32'($past(owed_count)) + 1)));

endmodule

bind refi_gen refi_gen_chk #(.OWED_MAX(OWED_MAX), .OWED_W(OWED_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req),
    .owed_count  (owed_count)
);

// File: tb/refi_gen_test.sv
module refi_gen_test;

    localparam int P1 = 100, P2 = 200, P3 = 1600;
    localparam int FA = 66, FB = 100, FC = 133;
    localparam int OMAX = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate = 2'b00;
    logic [1:0] freq = 2'b00;
    logic       ack = 1'b0;
    logic       req;
    logic [2:0] owed;

    int    total = 0;
    int    bad = 0;
    string tag = "R9";
    bit    done = 0;

    int         m_owed = 0;
    int         m_cnt = 0;
    logic [3:0] m_prev = 4'h0;

    always #5 clk = ~clk;

    refi_gen #(
        .RATE1_NS(P1), .RATE2_NS(P2), .RATE3_NS(P3),
        .F0_MHZ(FA), .F1_MHZ(FB), .F2_MHZ(FC), .OWED_MAX(OMAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate), .freq_sel(freq),
        .refresh_ack(ack), .refresh_req(req), .owed_count(owed)
    );

    // R2 / R3: interval length from the stated formula
    function automatic int interval(input logic [1:0] r, input logic [1:0] f);
        int ns, mhz, c;
        ns  = (r == 2'd1) ? P1 : (r == 2'd2) ? P2 : P3;
        mhz = (f == 2'd0) ? FA : (f == 2'd1) ? FB : FC;
        c = (ns * mhz) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    task automatic check(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int  nxt;
        bit  fire;
        if (!rst_n) begin
            m_owed = 0; m_cnt = 0; m_prev = 4'h0;
        end else if (rate == 2'b00) begin
            m_owed = 0; m_prev = {rate, freq};
        end else begin
            fire = 0;
            if ({rate, freq} != m_prev) begin
                m_cnt = interval(rate, freq) - 1;
                m_prev = {rate, freq};
            end else if (m_cnt == 0) begin
                fire = 1;
                m_cnt = interval(rate, freq) - 1;
            end else begin
                m_cnt--;
            end
            nxt = m_owed + (fire ? 1 : 0) - ((ack && m_owed > 0) ? 1 : 0);
            if (nxt > OMAX) nxt = OMAX;
            m_owed = nxt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({tag, " owed"}, int'(owed), m_owed);
            check({tag, " R10 req"}, int'(req), (m_owed != 0) ? 1 : 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R5 watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R9 reset req", int'(req), 0);
        check("R9 reset owed", int'(owed), 0);
        rst_n = 1'b1;

        // R1: disabled, acks ignored
        tag = "R1";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); ack = i[0];
        end
        ack = 1'b0;
        @(negedge clk);
        check("R1 idle owed", int'(owed), 0);

        // R4: first request L edges after the new setting is sampled (L=20)
        tag = "R4";
        rate = 2'b10; freq = 2'b01;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!req && n < 100);
        check("R4 first request latency", n, interval(2'b10, 2'b01) + 1);

        // R6: no acks, saturate at ceiling
        tag = "R6";
        repeat (200) @(negedge clk);
        check("R6 saturated owed", int'(owed), OMAX);

        // R5: drain with acks
        tag = "R5";
        for (int i = 0; i < 10; i++) begin
            ack = 1'b1; @(negedge clk);
        end
        ack = 1'b0;
        repeat (5) @(negedge clk);

        // R7: change settings mid-interval, owed kept
        tag = "R7";
        repeat (30) @(negedge clk);
        rate = 2'b01; freq = 2'b00;
        repeat (3) @(negedge clk);
        freq = 2'b10;
        repeat (7) @(negedge clk);
        freq = 2'b00;
        repeat (60) @(negedge clk);

        // R3: code 11 uses the top frequency, long period
        tag = "R3";
        rate = 2'b11; freq = 2'b11;
        repeat (500) @(negedge clk);
        freq = 2'b00;
        repeat (250) @(negedge clk);

        // R2: remaining period/clock combinations
        tag = "R2";
        for (int r = 1; r < 4; r++) begin
            for (int f = 0; f < 3; f++) begin
                rate = 2'(r); freq = 2'(f);
                repeat (interval(2'(r), 2'(f)) * 2 + 3) @(negedge clk);
                ack = 1'b1; @(negedge clk); ack = 1'b0;
            end
        end

        // R8: random acks against expiries
        tag = "R8";
        rate = 2'b01; freq = 2'b00;
        for (int i = 0; i < 800; i++) begin
            ack = ($urandom_range(0, 2) == 0);
            if (i == 400) freq = 2'b01;
            @(negedge clk);
        end
        ack = 1'b0;

        // R1: disable with refreshes owed
        tag = "R1";
        repeat (40) @(negedge clk);
        check("R1 owed before disable nonzero", (owed != 0) ? 1 : 0, 1);
        rate = 2'b00;
        @(negedge clk);
        check("R1 owed cleared", int'(owed), 0);
        check("R1 req dropped", int'(req), 0);
        for (int i = 0; i < 10; i++) begin
            ack = 1'b1; @(negedge clk);
        end
        ack = 1'b0;
        check("R1 stays clear", int'(owed), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule